// File: doc/BRIEF.md
# Output Fault Latch and Power-Good Supervisor

This block supervises a switching regulator's output. It takes digitized comparator flags for the output voltage and sets three things: the high-side and low-side gate-driver enables, a hold-on request for the low-side switch, and a pull-down for an open-drain power-good line. Before it acts on any comparator flag, it synchronizes the flag and requires it to hold steady for a set number of clocks.

The block latches two faults. An undervoltage fault is checked only after startup has finished, and it turns both drivers off. An overvoltage fault is checked as soon as the supply power-on reset clears. It turns the high side off and holds the low side on until a separate low-output comparator reports that the output has collapsed. Both faults stay latched until the supply power-on reset is asserted again. When no fault is present, power-good follows a window comparator once startup is done. If the output leaves the window, power-good drops but the drivers keep switching.

Top module: `vout_guard`

## Requirements
- R1: While `por_i` is high, the block drives `hs_en_o`=0, `ls_en_o`=0, `ls_hold_o`=0, `fault_o`=00 and `pg_pd_o`=1. The first clock with `por_i` high clears any latched fault.
- R2: A comparator flag (`uv_i`, `ov_i`, `low_i`, `win_i`) takes effect only after its synchronized value has differed from the accepted value for `STABLE_CYCLES` consecutive clocks. A shorter pulse has no effect on any output.
- R3: While `ss_done_i` is low, an undervoltage flag has no effect: the drivers stay enabled and `fault_o` stays 00.
- R4: A filtered undervoltage flag with `ss_done_i` high latches an undervoltage fault. The block then drives `fault_o`=01, `hs_en_o`=0, `ls_en_o`=0, `ls_hold_o`=0 and `pg_pd_o`=1.
- R5: A filtered overvoltage flag with `por_i` low latches an overvoltage fault whatever the state of `ss_done_i`. The block then drives `fault_o`=10, `hs_en_o`=0, `ls_en_o`=0, `ls_hold_o`=1 and `pg_pd_o`=1.
- R6: During an overvoltage fault, a filtered `low_i` releases `ls_hold_o` to 0 and `fault_o` stays 10. Once released, the hold does not come back while the fault stays latched.
- R7: A latched fault and its driver states persist after every comparator flag returns to its normal level, until `por_i` is raised.
- R8: If the filtered undervoltage and overvoltage flags become active in the same clock, the block latches the overvoltage fault (`fault_o`=10).
- R9: `pg_pd_o` is 0 only when `por_i` is low, `ss_done_i` is high, no fault is latched and the filtered window flag is high. When the window flag drops without a fault, `pg_pd_o` goes to 1 while `hs_en_o` and `ls_en_o` stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Supply power-on reset, active high, synchronous |
| ss_done_i | input | 1 | Soft-start finished, synchronous |
| uv_i | input | 1 | Output below undervoltage threshold (raw) |
| ov_i | input | 1 | Output above overvoltage threshold (raw) |
| low_i | input | 1 | Output below discharge release level (raw) |
| win_i | input | 1 | Output inside power-good window (raw) |
| hs_en_o | output | 1 | High-side driver switching enable |
| ls_en_o | output | 1 | Low-side driver switching enable |
| ls_hold_o | output | 1 | Hold low-side switch continuously on |
| fault_o | output | 2 | Latched fault: 00 none, 01 undervoltage, 10 overvoltage |
| pg_pd_o | output | 1 | Power-good pull-down, 1 = pulling line low |

## Verification
The undervoltage and overvoltage latches can be triggered in the same clock. The bench provokes this by raising both raw flags in the same cycle while startup is done, so both filters accept them on the same edge. It then checks that the outputs show the overvoltage code and the low-side hold, not the undervoltage code with both drivers off. A second overlap appears when startup completes while an undervoltage flag is still being filtered. The bench avoids that overlap in its sequence by clearing the flag before it raises startup-done.

// File: rtl/vout_guard_pkg.sv
package vout_guard_pkg;
  localparam int FLAG_N  = 4;
  localparam int IDX_UV  = 0;
  localparam int IDX_OV  = 1;
  localparam int IDX_LOW = 2;
  localparam int IDX_WIN = 3;

  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_UV   = 2'b01,
    FC_OV   = 2'b10
  } fault_code_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_UV,
    ST_OV_HOLD,
    ST_OV_OFF
  } guard_state_e;
endpackage

// File: rtl/flag_filter.sv
module flag_filter #(
  parameter int STABLE_CYCLES = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CNT_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   filt_q;
  logic                   sync_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign sync_v = sync_q[SYNC_STAGES-1];

  // accept a new level only after it differs for STABLE_CYCLES clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (sync_v == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q  <= '0;
      filt_q <= sync_v;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  a_r2_settle_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(cnt_q) == CNT_LAST && $past(sync_v) != $past(filt_q)));
endmodule

// File: rtl/fault_ctrl.sv
module fault_ctrl
  import vout_guard_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_i,
  input  logic        ss_done_i,
  input  logic        uv_i,
  input  logic        ov_i,
  input  logic        low_i,
  output logic        hs_en_o,
  output logic        ls_en_o,
  output logic        ls_hold_o,
  output logic        run_o,
  output logic [1:0]  fault_o
);
  guard_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (por_i) begin
      st_d = ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (ov_i)                 st_d = ST_OV_HOLD;  // overvoltage wins a tie
          else if (uv_i && ss_done_i) st_d = ST_UV;
        end
        ST_OV_HOLD: if (low_i) st_d = ST_OV_OFF;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign run_o     = !por_i && (st_q == ST_RUN);
  assign hs_en_o   = run_o;
  assign ls_en_o   = run_o;
  assign ls_hold_o = !por_i && (st_q == ST_OV_HOLD);

  always_comb begin
    fault_o = FC_NONE;
    if (!por_i) begin
      if (st_q == ST_UV)                              fault_o = FC_UV;
      else if (st_q == ST_OV_HOLD || st_q == ST_OV_OFF) fault_o = FC_OV;
    end
  end

  a_r1_por_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (st_q == ST_RUN));
  a_r3_uv_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !ss_done_i) |=> (st_q != ST_UV));
  a_r4_uv_drivers_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == FC_UV) |-> (!hs_en_o && !ls_en_o && !ls_hold_o));
  a_r5_ov_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !por_i && ov_i) |=> (por_i || (ls_hold_o && !hs_en_o)));
  a_r6_release_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OV_OFF && !por_i) |=> !ls_hold_o);
  a_r7_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RUN && !por_i) |=> (st_q != ST_RUN));
  a_r8_ov_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !por_i && uv_i && ov_i) |=> (st_q == ST_OV_HOLD));
endmodule

// File: rtl/pgood_drv.sv
module pgood_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic ss_done_i,
  input  logic run_i,
  input  logic win_i,
  input  logic hs_en_i,
  input  logic [1:0] fault_i,
  output logic pg_pd_o
);
  logic pd_q;

  // registered so the open-drain line never glitches on comb paths
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pd_q <= 1'b1;
    else         pd_q <= !(run_i && ss_done_i && win_i && !por_i);
  end

  assign pg_pd_o = pd_q;

  a_r9_fault_pulls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i != 2'b00) |=> pg_pd_o);
  a_r9_startup_pulls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_done_i |=> pg_pd_o);
  a_r9_good_means_switching: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pg_pd_o && !por_i && $past(!por_i)) |-> $past(hs_en_i));
endmodule

// File: rtl/vout_guard.sv
module vout_guard
  import vout_guard_pkg::*;
#(
  parameter int STABLE_CYCLES = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       ss_done_i,
  input  logic       uv_i,
  input  logic       ov_i,
  input  logic       low_i,
  input  logic       win_i,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic       ls_hold_o,
  output logic [1:0] fault_o,
  output logic       pg_pd_o
);
  logic [FLAG_N-1:0] raw_flags, filt_flags;
  logic run;

  assign raw_flags[IDX_UV]  = uv_i;
  assign raw_flags[IDX_OV]  = ov_i;
  assign raw_flags[IDX_LOW] = low_i;
  assign raw_flags[IDX_WIN] = win_i;

  for (genvar g = 0; g < FLAG_N; g++) begin : g_filt
    flag_filter #(
      .STABLE_CYCLES(STABLE_CYCLES),
      .SYNC_STAGES  (SYNC_STAGES)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_flags[g]),
      .filt_o(filt_flags[g])
    );
  end

  fault_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_i    (por_i),
    .ss_done_i(ss_done_i),
    .uv_i     (filt_flags[IDX_UV]),
    .ov_i     (filt_flags[IDX_OV]),
    .low_i    (filt_flags[IDX_LOW]),
    .hs_en_o  (hs_en_o),
    .ls_en_o  (ls_en_o),
    .ls_hold_o(ls_hold_o),
    .run_o    (run),
    .fault_o  (fault_o)
  );

  pgood_drv u_pg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_i    (por_i),
    .ss_done_i(ss_done_i),
    .run_i    (run),
    .win_i    (filt_flags[IDX_WIN]),
    .hs_en_i  (hs_en_o),
    .fault_i  (fault_o),
    .pg_pd_o  (pg_pd_o)
  );
endmodule

// File: tb/vout_guard_bench.sv
module vout_guard_bench;
  localparam int STABLE = 4;
  localparam int HOLD   = 12;
  localparam int NVEC   = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por, ss, uv, ov, low, win;
  logic hs, ls, hold, pd;
  logic [1:0] fault;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  vout_guard #(.STABLE_CYCLES(STABLE)) u_vout_guard (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .ss_done_i(ss),
    .uv_i(uv), .ov_i(ov), .low_i(low), .win_i(win),
    .hs_en_o(hs), .ls_en_o(ls), .ls_hold_o(hold),
    .fault_o(fault), .pg_pd_o(pd)
  );

  // {req, por ss uv ov low win, hs ls hold fault[1:0] pd}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd1, 6'b100000, 6'b000001},  // R1 por held
    {4'd9, 6'b000000, 6'b110001},  // R9 switching, startup not done
    {4'd3, 6'b001000, 6'b110001},  // R3 uv ignored before startup
    {4'd3, 6'b000000, 6'b110001},  // R3 uv cleared
    {4'd9, 6'b010001, 6'b110000},  // R9 good
    {4'd9, 6'b010000, 6'b110001},  // R9 out of window, still switching
    {4'd4, 6'b011001, 6'b000011},  // R4 uv fault
    {4'd7, 6'b010001, 6'b000011},  // R7 uv latched
    {4'd1, 6'b110001, 6'b000001},  // R1 por clears
    {4'd5, 6'b000100, 6'b001101},  // R5 ov before startup
    {4'd7, 6'b000000, 6'b001101},  // R7 ov latched, hold on
    {4'd6, 6'b000010, 6'b000101},  // R6 hold released
    {4'd6, 6'b000000, 6'b000101},  // R6 hold stays off
    {4'd1, 6'b100000, 6'b000001},  // R1
    {4'd8, 6'b011101, 6'b001101},  // R8 tie goes to ov
    {4'd1, 6'b100000, 6'b000001},  // R1
    {4'd9, 6'b010001, 6'b110000}   // R9 healthy again
  };

  task automatic check(input int req, input logic [5:0] got, input logic [5:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got hs,ls,hold,fault,pd=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {hs, ls, hold, fault, pd};
  endfunction

  task automatic drive(input logic [5:0] v);
    {por, ss, uv, ov, low, win} = v;
  endtask

  initial begin
    drive(6'b100000);
    repeat (3) @(negedge clk);
    check(1, outs(), 6'b000001);  // R1 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i][11:6]);
      repeat (HOLD) @(negedge clk);
      check(int'(VEC[i][15:12]), outs(), VEC[i][5:0]);
    end
    // R2: ov pulse shorter than the filter window is ignored
    ov = 1'b1;
    repeat (STABLE - 2) @(negedge clk);
    ov = 1'b0;
    repeat (HOLD) @(negedge clk);
    check(2, outs(), 6'b110000);
    // R2: pulse exactly at the window is accepted
    ov = 1'b1;
    repeat (STABLE) @(negedge clk);
    ov = 1'b0;
    repeat (HOLD) @(negedge clk);
    check(2, outs(), 6'b001101);
    // R1: por mid-fault clears at once
    por = 1'b1;
    @(negedge clk);
    check(1, outs(), 6'b000001);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule